// File: doc/BRIEF.md
# Branch and Conditional-Move Condition Unit

This unit decides whether a conditional jump or a conditional register move takes effect, and picks the program counter that follows a control-flow instruction. It takes the 4-bit instruction class and the 4-bit function selector of the current instruction, together with the zero, sign and overflow flags left by the last arithmetic operation. From these it produces a single condition bit. For jumps and calls the next PC is the absolute 32-bit destination carried in the instruction. For a return it is the word popped from the stack. In every other case it is the sequential address.

For a conditional move, the unit passes the destination register identifier through when the condition holds. When it does not, it replaces the identifier with the reserved code 0xF, which means "no register", so the write-back stage writes nothing. One seven-entry condition table serves both jumps and moves. A selector outside that table gives a false condition and raises an invalid-function flag.

All outputs are registered once, so a decode or execute stage sees the result one clock after it presents the operands.

Top module: `condUnit`

## Requirements
- R1: All outputs are registered and change on the rising clock edge following the inputs. While the active-low reset is asserted: condOut=0, funcBad=0, nextPc=0 and dstReg=0xF.
- R2: For class 2 (conditional move) or class 7 (jump), with less = sf XOR of, the function selector gives condOut as follows:
  - 0: always 1
  - 1: less OR zf
  - 2: less
  - 3: zf
  - 4: NOT zf
  - 5: NOT less
  - 6: NOT (less OR zf)
- R3: For class 2 or 7 with a function selector from 7 to 15, condOut=0 and funcBad=1.
- R4: For any class other than 2 and 7, condOut=0 and funcBad=0, whatever the flags and selector.
- R5: For class 7, nextPc equals valC when the condition holds and valP when it does not.
- R6: For class 8 (call), nextPc equals valC regardless of flags and selector.
- R7: For class 9 (return), nextPc equals valM regardless of flags and selector.
- R8: For every class other than 7, 8 and 9, nextPc equals valP.
- R9: For class 2, dstReg equals rB when the condition holds and 0xF otherwise (including an invalid selector).
- R10: For every class other than 2, dstReg equals rB unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 4 | Instruction class |
| funCode | input | 4 | Function selector (condition index) |
| zf | input | 1 | Zero flag |
| sf | input | 1 | Sign flag |
| of | input | 1 | Overflow flag |
| valC | input | 32 | Absolute destination from the instruction |
| valM | input | 32 | Return address popped from the stack |
| valP | input | 32 | Sequential next address |
| rB | input | 4 | Destination register identifier |
| condOut | output | 1 | Condition result |
| funcBad | output | 1 | Function selector outside the table |
| nextPc | output | 32 | Selected next program counter |
| dstReg | output | 4 | Destination register, 0xF when cancelled |

## Verification
The bench sweeps every class, selector and flag combination. This catches a condition that treats less as the sign flag alone: that condition would fail whenever overflow is set. It also catches a greater-than term that forgets the zero flag.

Selectors 7 to 15 are checked so that a design which wraps them into the table would show a true condition or a surviving register write. A not-taken jump must fall back to valP, not valC. A call must ignore the flags entirely. Register 0xF passed through a taken move must stay 0xF rather than be confused with a cancel.

// File: rtl/condUnitPkg.sv
package condUnitPkg;
  localparam int CODE_W   = 4;
  localparam int NUM_COND = 7;
  localparam logic [CODE_W-1:0] OP_CMOV = 4'h2;
  localparam logic [CODE_W-1:0] OP_JUMP = 4'h7;
  localparam logic [CODE_W-1:0] OP_CALL = 4'h8;
  localparam logic [CODE_W-1:0] OP_RET  = 4'h9;

  typedef struct packed {
    logic useTarget;
    logic useReturn;
    logic condHit;
    logic funcBad;
    logic cancelWrite;
  } strobe_t;
endpackage

// File: rtl/condCtrl.sv
module condCtrl
  import condUnitPkg::*;
(
  input  logic [CODE_W-1:0] opCode,
  input  logic [CODE_W-1:0] funCode,
  input  logic              zf,
  input  logic              sf,
  input  logic              of,
  output strobe_t           strobes
);
  function automatic logic condTerm(input int idx, input logic z, input logic s, input logic o);
    logic lt;
    lt = s ^ o;
    case (idx)
      0:       condTerm = 1'b1;
      1:       condTerm = lt | z;
      2:       condTerm = lt;
      3:       condTerm = z;
      4:       condTerm = ~z;
      5:       condTerm = ~lt;
      6:       condTerm = ~(lt | z);
      default: condTerm = 1'b0;
    endcase
  endfunction

  logic [NUM_COND-1:0] condVec;
  logic                condSel;
  logic                inRange;
  logic                isCond;

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    assign condVec[k] = condTerm(k, zf, sf, of);
  end

  assign inRange = (funCode < CODE_W'(NUM_COND));
  assign isCond  = (opCode == OP_CMOV) || (opCode == OP_JUMP);

  always_comb begin
    condSel = 1'b0;
    for (int k = 0; k < NUM_COND; k++) begin
      if (funCode == k[CODE_W-1:0]) condSel = condVec[k];
    end
  end

  always_comb begin
    strobes.condHit     = isCond & condSel;
    strobes.funcBad     = isCond & ~inRange;
    strobes.useTarget   = ((opCode == OP_JUMP) & condSel) | (opCode == OP_CALL);
    strobes.useReturn   = (opCode == OP_RET);
    strobes.cancelWrite = (opCode == OP_CMOV) & ~condSel;
  end
endmodule

// File: rtl/condPath.sv
module condPath
  import condUnitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] valC,
  input  logic [ADDR_W-1:0] valM,
  input  logic [ADDR_W-1:0] valP,
  input  logic [REG_W-1:0]  rB,
  output logic              condOut,
  output logic              funcBad,
  output logic [ADDR_W-1:0] nextPc,
  output logic [REG_W-1:0]  dstReg
);
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic [ADDR_W-1:0] pcNext;
  logic [REG_W-1:0]  regNext;

  always_comb begin
    if (strobes.useReturn)      pcNext = valM;
    else if (strobes.useTarget) pcNext = valC;
    else                        pcNext = valP;
    regNext = strobes.cancelWrite ? NO_REG : rB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condOut <= 1'b0;
      funcBad <= 1'b0;
      nextPc  <= '0;
      dstReg  <= NO_REG;
    end else begin
      condOut <= strobes.condHit;
      funcBad <= strobes.funcBad;
      nextPc  <= pcNext;
      dstReg  <= regNext;
    end
  end
endmodule

// File: rtl/condUnit.sv
module condUnit
  import condUnitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic [3:0]        funCode,
  input  logic              zf,
  input  logic              sf,
  input  logic              of,
  input  logic [ADDR_W-1:0] valC,
  input  logic [ADDR_W-1:0] valM,
  input  logic [ADDR_W-1:0] valP,
  input  logic [REG_W-1:0]  rB,
  output logic              condOut,
  output logic              funcBad,
  output logic [ADDR_W-1:0] nextPc,
  output logic [REG_W-1:0]  dstReg
);
  strobe_t strobes;

  condCtrl u_ctrl (
    .opCode(opCode), .funCode(funCode), .zf(zf), .sf(sf), .of(of), .strobes(strobes)
  );

  condPath #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .valC(valC), .valM(valM), .valP(valP),
    .rB(rB), .condOut(condOut), .funcBad(funcBad), .nextPc(nextPc), .dstReg(dstReg)
  );
endmodule

// File: rtl/condUnitChk.sv
module condUnitChk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic [3:0]        funCode,
  input logic              zf,
  input logic              sf,
  input logic              of,
  input logic [ADDR_W-1:0] valC,
  input logic [ADDR_W-1:0] valM,
  input logic [ADDR_W-1:0] valP,
  input logic [REG_W-1:0]  rB,
  input logic              condOut,
  input logic              funcBad,
  input logic [ADDR_W-1:0] nextPc,
  input logic [REG_W-1:0]  dstReg
);
  // R3
  bad_func_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opCode == 4'h2 || opCode == 4'h7) && funCode > 4'h6) |=> (funcBad && !condOut));
  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    funcBad |-> !condOut);
  // R5
  jump_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h7 && funCode == 4'h0) |=> (condOut && nextPc == $past(valC)));
  // R6
  call_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h8) |=> (nextPc == $past(valC)));
  // R7
  ret_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h9) |=> (nextPc == $past(valM)));
  // R8
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode < 4'h7 || opCode > 4'h9) |=> (nextPc == $past(valP)));
  // R9
  cmov_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h2 && funCode > 4'h6) |=> (dstReg == '1));
  // R10
  pass_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode != 4'h2) |=> (dstReg == $past(rB)));
endmodule

bind condUnit condUnitChk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_condUnit.sv
module sim_condUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = '0, funCode = '0, rB = '0;
  logic        zf = 1'b0, sf = 1'b0, of = 1'b0;
  logic [31:0] valC = '0, valM = '0, valP = '0;
  logic        condOut, funcBad;
  logic [31:0] nextPc;
  logic [3:0]  dstReg;
  int          nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  condUnit u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .funCode(funCode), .zf(zf), .sf(sf), .of(of),
    .valC(valC), .valM(valM), .valP(valP), .rB(rB),
    .condOut(condOut), .funcBad(funcBad), .nextPc(nextPc), .dstReg(dstReg)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h (op %h fn %h zsf %b%b%b)",
               tag, act, exp, opCode, funCode, zf, sf, of);
    end
  endtask

  function automatic logic refCond(input logic [3:0] fn, input logic z, input logic s, input logic o);
    logic lt;
    lt = s ^ o;
    case (fn)
      4'd0: return 1'b1;
      4'd1: return lt | z;
      4'd2: return lt;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !lt;
      4'd6: return !(lt | z);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 condOut", {31'b0, condOut}, 32'd0);
    check("R1 funcBad", {31'b0, funcBad}, 32'd0);
    check("R1 nextPc", nextPc, 32'd0);
    check("R1 dstReg", {28'b0, dstReg}, 32'hF);
    rstN = 1'b1;
    for (int idx = 0; idx < 2048; idx++) begin
      logic isCond, c;
      logic [31:0] expPc;
      logic [3:0]  expReg;
      @(negedge clk);
      opCode  = 4'(idx >> 7);
      funCode = 4'(idx >> 3);
      {zf, sf, of} = 3'(idx);
      valC = 32'hC0DE_0000 | 32'(idx);
      valM = 32'hBEEF_0000 | 32'(idx * 3);
      valP = 32'h0A00_0000 | 32'(idx * 5);
      rB   = 4'(idx) ^ 4'(idx >> 4);
      isCond = (opCode == 4'h2) || (opCode == 4'h7);
      c = refCond(funCode, zf, sf, of);
      if (opCode == 4'h7) expPc = c ? valC : valP;
      else if (opCode == 4'h8) expPc = valC;
      else if (opCode == 4'h9) expPc = valM;
      else expPc = valP;
      expReg = (opCode == 4'h2 && !c) ? 4'hF : rB;
      @(negedge clk);
      if (isCond && funCode > 4'h6) begin
        check("R3 condOut", {31'b0, condOut}, 32'd0);
        check("R3 funcBad", {31'b0, funcBad}, 32'd1);
      end else if (isCond) begin
        check("R2 condOut", {31'b0, condOut}, {31'b0, c});
        check("R2 funcBad", {31'b0, funcBad}, 32'd0);
      end else begin
        check("R4 condOut", {31'b0, condOut}, 32'd0);
        check("R4 funcBad", {31'b0, funcBad}, 32'd0);
      end
      if (opCode == 4'h7)      check("R5 nextPc", nextPc, expPc);
      else if (opCode == 4'h8) check("R6 nextPc", nextPc, expPc);
      else if (opCode == 4'h9) check("R7 nextPc", nextPc, expPc);
      else                     check("R8 nextPc", nextPc, expPc);
      if (opCode == 4'h2) check("R9 dstReg", {28'b0, dstReg}, {28'b0, expReg});
      else                check("R10 dstReg", {28'b0, dstReg}, {28'b0, expReg});
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule